// File: doc/BRIEF.md
# Phase-Steering Dual Event Counter

This block holds two 8-bit up counters that count rising edges on two external pulse inputs, A and B. The inputs are already filtered and synchronous to the system clock. Each counter steps by one on a rising edge of the input routed to it. The mode bit selects one of two routings. In separate mode, A feeds counter 0 and B feeds counter 1. In phase detection mode, the block tracks which of the two inputs leads and sends that input's edges to one counter. When A leads, counter 1 counts. When B leads, counter 0 counts. The direction of rotation of a two-phase source therefore shows up as the counter that grows.

Software uses a small register interface that is 4 bits wide. Each count is read as two nibbles, and one control nibble holds two clear strobes, a run/stop request and the mode bit. A new run/stop value does not act at once. It is taken over on the next falling edge of a slow sampling clock, which is the same clock that drives the input filter.

Top module: `phase_event_counter`

## Requirements
- R1: After reset both counts read 00h, and the control nibble reads 0000b, which means stopped and phase detection mode.
- R2: With the mode bit at 1 (separate mode) and the block running, each rising edge of A adds one to counter 0 and each rising edge of B adds one to counter 1. This also holds when both inputs rise in the same cycle.
- R3: With the mode bit at 0 (phase detection mode), A leads when it rises while B is low. The edges of a leading A then add one to counter 1 only.
- R4: In phase detection mode, B leads when it rises while A is low. The edges of a leading B then add one to counter 0 only.
- R5: A counter increments on the rising edge of its input. That edge is visible one clock after the input goes high, and the counter wraps from FFh to 00h.
- R6: The control nibble is at address 4. Bit 0 clears counter 0, bit 1 clears counter 1, bit 2 is the run request and bit 3 is the mode. A read of address 4 returns mode and run as written, and returns bits 1:0 as 0.
- R7: Writing 1 to a clear bit sets its own counter to 00h and leaves the other counter alone. Writing 0 to a clear bit has no effect.
- R8: While the block is stopped, input edges leave both counts unchanged.
- R9: A written run/stop value takes effect only after the next falling edge of samp_clk. Until then, the previous run state stays in force.
- R10: If a clear and a count edge for the same counter arrive in the same cycle, the counter reads 00h afterwards.
- R11: Address 0 holds the low nibble of counter 0 and address 1 its high nibble. Address 2 holds the low nibble of counter 1 and address 3 its high nibble. Writes to addresses 0 to 3 change nothing, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_clk | input | 1 | Sampling clock; its falling edge commits run/stop |
| in_a | input | 1 | Filtered pulse input A |
| in_b | input | 1 | Filtered pulse input B |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble for reg_addr |

## Verification
The bench sweeps several pulse counts, some of them past 255. A counter that saturates, or that drops its carry into the high nibble, reads back the wrong pair of nibbles. In phase detection mode it drives A-leading and B-leading quadrature sequences. A design that swapped the steering, or that also counted on the lagging input, moves the wrong counter or counts twice per period. The bench writes run/stop and then sends pulses before any sampling-clock fall. A design that applied the run bit at once counts edges that should be ignored, or drops edges that should still count. It also lands a clear and a count edge in the same cycle, and writes to the count addresses. A priority error or a decode error leaves a nonzero count behind.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic {LEAD_B = 1'b0, LEAD_A = 1'b1} lead_e;

  // control nibble bit positions
  localparam int CTL_CLR0 = 0;
  localparam int CTL_CLR1 = 1;
  localparam int CTL_RUN  = 2;
  localparam int CTL_MODE = 3;

  // input lane indices
  localparam int IN_A = 0;
  localparam int IN_B = 1;
endpackage

// File: rtl/evc_edge.sv
module evc_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/evc_steer.sv
module evc_steer
  import evc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       sep_mode,
  input  logic [1:0] lvl,
  input  logic [1:0] rise,
  output logic [1:0] inc
);
  lead_e lead_q, lead_now;
  logic  phase_ev;
  logic [1:0] inc_phase;

  // a leading input sends its edges to the opposite-index counter
  function automatic logic [1:0] route(lead_e ld, logic ev);
    return (ld == LEAD_A) ? {ev, 1'b0} : {1'b0, ev};
  endfunction

  always_comb begin
    if (rise[IN_A] && !lvl[IN_B])      lead_now = LEAD_A;
    else if (rise[IN_B] && !lvl[IN_A]) lead_now = LEAD_B;
    else                               lead_now = lead_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead_q <= LEAD_B;
    else        lead_q <= lead_now;
  end

  assign phase_ev  = (lead_now == LEAD_A) ? rise[IN_A] : rise[IN_B];
  assign inc_phase = route(lead_now, phase_ev);
  assign inc       = !run ? 2'b00 : (sep_mode ? rise : inc_phase);
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= bump(count);
  end
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_clk,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [NIB_W-1:0]   reg_wdata,
  input  logic [2*CNT_W-1:0] cnt_flat,
  output logic [NIB_W-1:0]   reg_rdata,
  output logic [1:0]         clr,
  output logic               run_eff,
  output logic               sep_mode,
  output logic               samp_fall
);
  localparam int NPC      = CNT_W / NIB_W;
  localparam int NCNT_NIB = 2 * NPC;
  localparam int CTL_ADDR = NCNT_NIB;

  logic samp_q, run_req, mode_q, ctl_wr;

  function automatic logic [NIB_W-1:0] pick(logic [2*CNT_W-1:0] f, int idx);
    return f[idx*NIB_W +: NIB_W];
  endfunction

  assign ctl_wr    = reg_wr && (reg_addr == ADDR_W'(CTL_ADDR));
  assign samp_fall = samp_q && !samp_clk;
  assign clr[0]    = ctl_wr && reg_wdata[CTL_CLR0];
  assign clr[1]    = ctl_wr && reg_wdata[CTL_CLR1];
  assign sep_mode  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      run_req <= 1'b0;
      mode_q  <= 1'b0;
      run_eff <= 1'b0;
    end else begin
      samp_q <= samp_clk;
      if (ctl_wr) begin
        run_req <= reg_wdata[CTL_RUN];
        mode_q  <= reg_wdata[CTL_MODE];
      end
      if (samp_fall) run_eff <= run_req;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) < NCNT_NIB) begin
      reg_rdata = pick(cnt_flat, int'(reg_addr));
    end else if (int'(reg_addr) == CTL_ADDR) begin
      reg_rdata[CTL_MODE] = mode_q;
      reg_rdata[CTL_RUN]  = run_req;
    end
  end
endmodule

// File: rtl/phase_event_counter.sv
module phase_event_counter #(
  parameter int CNT_W  = 8,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_clk,
  input  logic              in_a,
  input  logic              in_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NIB_W-1:0]  reg_wdata,
  output logic [NIB_W-1:0]  reg_rdata
);
  logic [1:0] lvl, rise, inc, clr;
  logic       run_eff, sep_mode, samp_fall;
  logic [1:0][CNT_W-1:0] cnt;
  logic [2*CNT_W-1:0]    cnt_flat;

  assign lvl      = {in_b, in_a};
  assign cnt_flat = cnt;

  evc_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  evc_steer u_steer (
    .clk(clk), .rst_n(rst_n), .run(run_eff), .sep_mode(sep_mode),
    .lvl(lvl), .rise(rise), .inc(inc)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    evc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr[g]), .inc(inc[g]), .count(cnt[g])
    );
  end

  evc_regs #(.CNT_W(CNT_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cnt_flat(cnt_flat), .reg_rdata(reg_rdata), .clr(clr),
    .run_eff(run_eff), .sep_mode(sep_mode), .samp_fall(samp_fall)
  );
endmodule

// File: rtl/phase_event_counter_chk.sv
module phase_event_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sep_mode,
  input logic                  run_eff,
  input logic                  samp_fall,
  input logic [1:0]            rise,
  input logic [1:0]            inc,
  input logic [1:0]            clr,
  input logic [1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < 2; g++) begin : g_c
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> cnt[g] == '0);
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inc[g] && !clr[g] |=> cnt[g] == CNT_W'($past(cnt[g]) + 1));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !inc[g] && !clr[g] |=> $stable(cnt[g]));
  end

  assert_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_eff |-> inc == 2'b00);
  assert_run_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_fall |=> $stable(run_eff));
  assert_phase_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sep_mode |-> $onehot0(inc));
  assert_separate_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sep_mode && run_eff |-> inc == rise);
endmodule

bind phase_event_counter phase_event_counter_chk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .run_eff(run_eff),
  .samp_fall(samp_fall), .rise(rise), .inc(inc), .clr(clr), .cnt(cnt)
);

// File: tb/phase_event_counter_test.sv
module phase_event_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_clk = 1'b0;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;

  int total = 0;
  int bad = 0;
  int e0 = 0;
  int e1 = 0;

  always #5 clk = ~clk;

  phase_event_counter uut (
    .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .in_a(in_a), .in_b(in_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd_cnt(input int idx, output int v);
    int lo, hi;
    rd(2*idx, lo);
    rd(2*idx + 1, hi);
    v = hi * 16 + lo;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 4'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // control nibble: bit3 mode, bit2 run, bit1 clr1, bit0 clr0
  function automatic int ctl(int mode, int run, int c1, int c0);
    return mode*8 + run*4 + c1*2 + c0;
  endfunction

  task automatic samp_tick();
    @(negedge clk); samp_clk = 1'b1;
    @(negedge clk); samp_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk); in_a = a; in_b = b;
    @(negedge clk); in_a = 1'b0; in_b = 1'b0;
  endtask

  // one quadrature period, leader rises first and falls first
  task automatic quad(input bit a_leads);
    @(negedge clk); if (a_leads) in_a = 1'b1; else in_b = 1'b1;
    @(negedge clk); if (a_leads) in_b = 1'b1; else in_a = 1'b1;
    @(negedge clk); if (a_leads) in_a = 1'b0; else in_b = 1'b0;
    @(negedge clk); if (a_leads) in_b = 1'b0; else in_a = 1'b0;
  endtask

  task automatic chk_counts(string req);
    int v;
    rd_cnt(0, v); check({req, " cnt0"}, v, e0 % 256);
    rd_cnt(1, v); check({req, " cnt1"}, v, e1 % 256);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_counts("R1");
    rd(4, v); check("R1 ctl", v, 0);

    // R9 run request not applied before sampling-clock fall
    wr(4, ctl(1, 1, 0, 0));
    rd(4, v); check("R6 readback", v, 12);
    pulse(1, 0);
    chk_counts("R9 before fall");
    samp_tick();

    // R2 R5 sweep in separate mode, with wrap
    for (int k = 0; k < 6; k++) begin
      int n = k * 53 + 1;
      wr(4, ctl(1, 1, 1, 1));
      e0 = 0; e1 = 0;
      for (int i = 0; i < n; i++) begin
        bit both = (i % 3 == 0);
        pulse(1, both);
        e0++;
        if (both) e1++;
      end
      chk_counts("R2 R5 sweep");
    end

    // R7 clear only counter 1; zero clear bits do nothing
    wr(4, ctl(1, 1, 0, 0));
    chk_counts("R7 zero write");
    wr(4, ctl(1, 1, 1, 0));
    e1 = 0;
    chk_counts("R7 clear1");
    rd(4, v); check("R6 clr reads zero", v, 12);

    // R11 count addresses ignore writes, upper addresses read 0
    wr(0, 4'hF); wr(3, 4'hF);
    chk_counts("R11 write ignored");
    rd(5, v); check("R11 addr5", v, 0);
    rd(7, v); check("R11 addr7", v, 0);

    // R10 clear and count edge together
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 4'(ctl(1, 1, 0, 1)); reg_wr = 1'b1; in_a = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; in_a = 1'b0;
    e0 = 0;
    chk_counts("R10 clear wins");

    // R3 A leads -> counter 1; R4 B leads -> counter 0
    wr(4, ctl(0, 1, 1, 1));
    e0 = 0; e1 = 0;
    for (int i = 0; i < 7; i++) quad(1'b1);
    e1 += 7;
    chk_counts("R3 A leads");
    for (int i = 0; i < 5; i++) quad(1'b0);
    e0 += 5;
    chk_counts("R4 B leads");
    rd(4, v); check("R6 phase mode", v, 4);

    // R9 stop still counting before fall, R8 ignored after
    wr(4, ctl(0, 0, 0, 0));
    quad(1'b0);
    e0 += 1;
    chk_counts("R9 stop pending");
    samp_tick();
    quad(1'b0); quad(1'b1);
    wr(4, ctl(1, 0, 0, 0));
    pulse(1, 1);
    chk_counts("R8 stopped");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule